// File: doc/BRIEF.md
# Asymmetric Subvector Element Mover

The block moves elements inside a small byte-addressed register file that it holds itself. One side of each move is a packed subvector of one to four elements. The other side is a single element. In gather mode, a group of source elements is concatenated into one destination element. In scatter mode, one source element is cut into a group of destination elements. The two sides can use different element widths, so one command can pack bytes into words or split a doubleword into halfwords. Because only one operand carries the group stride, the source and destination indices advance at different rates.

A host loads and inspects the file through a byte write port and a combinational byte read port. A command latches the mode, the two base element indices, the vector length, the group size, the two width codes and a predicate mask. The block then handles one vector index per clock and pulses `done` once the last index has been handled.

Top module: `subvec_mover`

## Requirements
- R1: During and after reset, `busy` and `done` are 0 and every byte of the register file reads 0.
- R2: While `busy` is 0, `host_we`=1 writes `host_wdata` to byte `host_waddr`. `host_rdata` always shows byte `host_raddr` combinationally. A host write presented while `busy` is 1 is ignored.
- R3: A `start` sampled while idle with `vec_len`=N≥1 latches every command input. `busy` is then 1 for the next N cycles, one vector index per cycle. `done` is 1 for exactly the one cycle after that. A `start` sampled while `busy` is 1 is ignored.
- R4: A `start` with `vec_len`=0 leaves the register file unchanged. It raises `done` for one cycle in the next cycle, and `busy` stays 0.
- R5: Element e with width code w (0,1,2,3 = 8,16,32,64 bits) occupies bytes e·2^w to e·2^w+2^w−1, little-endian. The group size is S = `sub_len`+1. With `mode`=0 (gather), destination element `dst_base`+i is built from source elements `src_base`+i·S+k for k=0..S−1. Source element k is placed at bit offset k times the source width.
- R6: When the assembled value is wider than the destination element, it is truncated to the low bits. When it is narrower, the remaining high bits are written as zero. For example, three bytes gathered into a 32-bit element give a top byte of 0.
- R7: With `mode`=1 (scatter), destination elements `dst_base`+i·S+k for k=0..S−1 receive consecutive destination-width slices of source element `src_base`+i, lowest slice first. Slices beyond the source width are zero.
- R8: When bit i of the latched `pred` is 0, index i writes nothing, and its destination bytes keep their values.
- R9: With S=1 and equal widths, the command is a plain element-by-element copy.
- R10: Byte addresses wrap modulo the file size (256 bytes). A group that runs past the top byte continues at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write enable |
| host_waddr | input | 8 | Host write byte address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 8 | Host read byte address |
| host_rdata | output | 8 | Host read data (combinational) |
| start | input | 1 | Command strobe |
| mode | input | 1 | 0 gather, 1 scatter |
| src_base | input | 8 | Source base element index |
| dst_base | input | 8 | Destination base element index |
| vec_len | input | 5 | Vector length, 0 to 16 |
| sub_len | input | 2 | Group size minus one |
| src_wc | input | 2 | Source width code |
| dst_wc | input | 2 | Destination width code |
| pred | input | 16 | Per-index predicate mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are windows that cross the top of the file and commands that overlap host traffic. The stimulus gets to the first by placing a 64-bit gather group at the last element index, so that its second half wraps to byte 0. It gets to the second by presenting a host write and a second `start` in the first busy cycle of a command. A reference model updates its own byte image element by element on every clock. The bench compares that image against the read port in every cycle and sweeps the whole file after each command, so a byte touched by mistake, such as a skipped predicate lane or an ignored host write, is caught.

// File: rtl/subvec_mover.sv
module subvec_mover #(
  parameter int NBYTES = 256,
  parameter int MAXVL  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_we,
  input  logic [$clog2(NBYTES)-1:0]    host_waddr,
  input  logic [7:0]                   host_wdata,
  input  logic [$clog2(NBYTES)-1:0]    host_raddr,
  output logic [7:0]                   host_rdata,
  input  logic                         start,
  input  logic                         mode,
  input  logic [$clog2(NBYTES)-1:0]    src_base,
  input  logic [$clog2(NBYTES)-1:0]    dst_base,
  input  logic [$clog2(MAXVL+1)-1:0]   vec_len,
  input  logic [1:0]                   sub_len,
  input  logic [1:0]                   src_wc,
  input  logic [1:0]                   dst_wc,
  input  logic [MAXVL-1:0]             pred,
  output logic                         busy,
  output logic                         done
);
  localparam int AW  = $clog2(NBYTES);
  localparam int LW  = $clog2(MAXVL+1);
  localparam int IW  = $clog2(MAXVL);
  localparam int WIN = 32;

  logic [7:0]       mem [NBYTES];
  logic             mode_q;
  logic [AW-1:0]    sb_q, db_q;
  logic [LW-1:0]    vl_q, idx;
  logic [1:0]       sl_q, sw_q, dw_q;
  logic [MAXVL-1:0] pred_q;

  wire [2:0]    grp    = {1'b0, sl_q} + 3'd1;
  wire [AW-1:0] idx_a  = AW'(idx);
  wire [AW-1:0] idx_g  = AW'(idx * grp);
  wire [AW-1:0] src_el = mode_q ? sb_q + idx_a : sb_q + idx_g;
  wire [AW-1:0] dst_el = mode_q ? db_q + idx_g : db_q + idx_a;
  wire [AW-1:0] src_addr = src_el << sw_q;
  wire [AW-1:0] dst_addr = dst_el << dw_q;
  wire [5:0]    src_len  = mode_q ? (6'd1 << sw_q) : ({3'd0, grp} << sw_q);
  wire [5:0]    dst_len  = mode_q ? ({3'd0, grp} << dw_q) : (6'd1 << dw_q);
  wire          pred_bit = pred_q[idx[IW-1:0]];
  wire          xfer     = busy & pred_bit;
  wire          last     = (idx == vl_q - LW'(1));

  assign host_rdata = mem[host_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NBYTES; a++) mem[a] <= 8'h00;
    end else if (busy) begin
      for (int j = 0; j < WIN; j++)
        if (xfer && (6'(j) < dst_len))
          mem[dst_addr + AW'(j)] <= (6'(j) < src_len) ? mem[src_addr + AW'(j)] : 8'h00;
    end else if (host_we) begin
      mem[host_waddr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; idx <= '0; mode_q <= 1'b0;
      sb_q <= '0; db_q <= '0; vl_q <= '0; sl_q <= '0;
      sw_q <= '0; dw_q <= '0; pred_q <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + LW'(1);
      end
    end else begin
      done <= 1'b0;
      if (start) begin
        mode_q <= mode; sb_q <= src_base; db_q <= dst_base; vl_q <= vec_len;
        sl_q <= sub_len; sw_q <= src_wc; dw_q <= dst_wc; pred_q <= pred;
        idx  <= '0;
        busy <= (vec_len != '0);
        done <= (vec_len == '0);
      end
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < vl_q));

  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(sb_q) && $stable(db_q) && $stable(mode_q) && $stable(pred_q)));

  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));

  p_host_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && !xfer) |=> (mem[$past(host_waddr)] == $past(mem[host_waddr])));
endmodule

// File: tb/subvec_mover_tb.sv
module subvec_mover_tb;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, start = 0, mode = 0;
  logic [7:0] host_waddr = 0, host_wdata = 0, host_raddr = 0, src_base = 0, dst_base = 0;
  logic [7:0] host_rdata;
  logic [4:0] vec_len = 0;
  logic [1:0] sub_len = 0, src_wc = 0, dst_wc = 0;
  logic [15:0] pred = 0;
  logic busy, done;

  subvec_mover u_dut (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata), .start(start),
    .mode(mode), .src_base(src_base), .dst_base(dst_base), .vec_len(vec_len), .sub_len(sub_len),
    .src_wc(src_wc), .dst_wc(dst_wc), .pred(pred), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [7:0] rm [256];
  int m_busy = 0, m_done = 0, m_i = 0;
  int q_mode, q_sb, q_db, q_vl, q_s, q_sw, q_dw;
  logic [15:0] q_pred;

  function automatic logic [63:0] rd_el(input int e, input int wc);
    logic [63:0] v = 0;
    int nb = 1 << wc;
    for (int b = 0; b < nb; b++) v[b*8 +: 8] = rm[(e*nb + b) % 256];
    return v;
  endfunction

  task automatic wr_el(input int e, input int wc, input logic [63:0] v);
    int nb = 1 << wc;
    for (int b = 0; b < nb; b++) rm[(e*nb + b) % 256] = v[b*8 +: 8];
  endtask

  task automatic model_xfer(input int i);
    logic [255:0] acc = 0;
    if (q_mode == 0) begin
      for (int k = 0; k < q_s; k++)
        acc = acc | ({192'd0, rd_el(q_sb + i*q_s + k, q_sw)} << (k * 8 * (1 << q_sw)));
      wr_el(q_db + i, q_dw, acc[63:0]);
    end else begin
      acc = {192'd0, rd_el(q_sb + i, q_sw)};
      for (int k = 0; k < q_s; k++) begin
        logic [255:0] sl = acc >> (k * 8 * (1 << q_dw));
        wr_el(q_db + i*q_s + k, q_dw, sl[63:0]);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) rm[a] = 8'h00;
      m_busy = 0; m_done = 0; m_i = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (q_pred[m_i]) model_xfer(m_i);
        if (m_i == q_vl - 1) begin m_busy = 0; m_done = 1; end
        else m_i++;
      end else begin
        if (host_we) rm[host_waddr] = host_wdata;
        if (start) begin
          q_mode = mode; q_sb = src_base; q_db = dst_base; q_vl = vec_len;
          q_s = sub_len + 1; q_sw = src_wc; q_dw = dst_wc; q_pred = pred; m_i = 0;
          if (vec_len == 0) m_done = 1; else m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    chk(busy === (m_busy != 0), "R3 busy", 64'(busy), 64'(m_busy));
    chk(done === (m_done != 0), "R3 done", 64'(done), 64'(m_done));
    chk(host_rdata === rm[host_raddr], cur_tag, 64'(host_rdata), 64'(rm[host_raddr]));
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  task automatic sweep(input string t);
    cur_tag = t;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); host_raddr = 8'(a);
    end
    @(negedge clk);
  endtask

  task automatic peek(input int addr, input logic [7:0] exp, input string t);
    @(negedge clk); host_raddr = 8'(addr);
    #3;
    chk(host_rdata === exp, t, 64'(host_rdata), 64'(exp));
  endtask

  task automatic run(input bit md, input int sb, input int db, input int vl, input int s,
                     input int sw, input int dw, input logic [15:0] pr, input string t,
                     input bit disturb);
    int cnt = 0;
    int expc = (vl == 0) ? 1 : vl + 1;
    @(negedge clk);
    mode = md; src_base = 8'(sb); dst_base = 8'(db); vec_len = 5'(vl);
    sub_len = 2'(s - 1); src_wc = 2'(sw); dst_wc = 2'(dw); pred = pr; start = 1;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 1) begin
        start = 0;
        if (disturb) begin
          host_we = 1; host_waddr = 8'd250; host_wdata = 8'hEE;
          start = 1; src_base = 8'd99; mode = ~md;
        end
      end else if (cnt == 2) begin
        host_we = 0; start = 0;
      end
    end while (!done && cnt < 200);
    host_we = 0; start = 0;
    chk(cnt == expc, (vl == 0) ? "R4 latency" : "R3 latency", 64'(cnt), 64'(expc));
    sweep(t);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk(busy === 1'b0 && done === 1'b0, "R1 reset outputs", 64'({busy, done}), 64'd0);
    rst_n = 1;
    sweep("R1 memory clear");
    cur_tag = "R2";
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); host_we = 1; host_waddr = 8'(a); host_wdata = pat(a);
    end
    @(negedge clk); host_we = 0;
    sweep("R2 host load");
    peek(77, pat(77), "R2 readback");

    run(0, 0, 16, 4, 4, 0, 2, 16'hFFFF, "R5 gather 8to32", 0);
    peek(65, pat(1), "R5 byte1 of group");
    peek(79, pat(15), "R5 last byte");

    run(0, 32, 40, 3, 3, 0, 2, 16'hFFFF, "R6 vec3 pad", 0);
    peek(160, pat(32), "R6 low byte");
    peek(163, 8'h00, "R6 top byte zero");
    peek(171, 8'h00, "R6 top byte zero i2");

    run(1, 8, 200, 2, 4, 2, 0, 16'hFFFF, "R7 scatter / R2 R3 ignored", 1);
    peek(201, pat(33), "R7 slice1");
    peek(250, pat(250), "R2 write while busy ignored");

    run(1, 5, 60, 3, 2, 0, 1, 16'hFFFF, "R7 scatter zero slice", 0);
    peek(120, pat(5), "R7 low slice");
    peek(121, 8'h00, "R6 zero extend");
    peek(122, 8'h00, "R7 slice beyond source");

    run(0, 0, 10, 4, 2, 1, 2, 16'h0005, "R8 predicate", 0);
    peek(40, pat(0), "R8 active lane");
    peek(44, pat(44), "R8 skipped lane unchanged");

    run(0, 1, 12, 3, 1, 3, 3, 16'hFFFF, "R9 plain copy", 0);
    peek(97, pat(9), "R9 copied byte");

    run(0, 2, 128, 8, 1, 3, 0, 16'hFFFF, "R6 truncate", 0);
    peek(128, pat(16), "R6 truncated low byte");

    run(0, 31, 4, 2, 2, 3, 3, 16'hFFFF, "R10 wrap", 0);
    peek(33, pat(249), "R10 pre-wrap byte");
    peek(40, pat(8), "R10 wrapped byte");

    run(1, 7, 3, 0, 2, 0, 0, 16'hFFFF, "R4 zero length", 0);
    run(0, 0, 180, 16, 1, 0, 0, 16'hA5C3, "R8 full length mask", 0);
    run(1, 0, 70, 2, 3, 3, 1, 16'hFFFF, "R7 scatter truncate", 0);
    run(1, 3, 6, 2, 4, 0, 3, 16'hFFFF, "R6 wide window", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule